// File: doc/BRIEF.md
# Trap Entry State Updater

This block is the state-commit stage of a processor's trap entry. When a trap is taken it works out the new control state from the current state. That state covers the trap level, the global register level, the processor status word and the hypervisor status word. It also captures the values the trap handler needs later: the saved program counter, the saved next program counter and a packed saved-state word. All results are registered and commit together on the clock edge where the trap request is high.

There are three kinds of entry, and each applies its own status-bit rules:

- **Privileged entry** is the default kind.
- **Hyperprivileged entry** is selected by `to_hyper`.
- **Error-state (RED) entry** is selected by `red_trap`. It takes precedence over `to_hyper`.

When the address-mask bit is set, the saved program counters are truncated. The global level saturates at a configured maximum. The surrounding pipeline feeds the registered outputs back as the current-state inputs for the next trap. Vector address generation, register window rotation and fetch redirection are handled elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: After synchronous active-low reset, every output (saved_pc, saved_npc, saved_state, new_pstate, new_hpstate, new_tl, new_gl) is zero.
- R2: While trap_req is low, every output keeps its value regardless of the other inputs.
- R3: On a trap, new_tl becomes cur_tl + 1 modulo 2^TL_W (TL_W defaults to 3, so 7 wraps to 0).
- R4: On a trap, new_gl becomes cur_gl + 1, capped at MAX_GL (default 2). A cur_gl already at or above MAX_GL gives MAX_GL.
- R5: On a trap, saved_state holds the old global level in bits 42:40, the old 12-bit status word in bits 19:8, the 8-bit trap type in bits 7:0, and zero in all other bits.
- R6: On a trap, saved_pc and saved_npc take cur_pc and cur_npc. If cur_pstate bit 3 (address mask) is set, only the low 32 bits are kept and the upper 32 bits are zero.
- R7: On a privileged entry (both to_hyper and red_trap low), the following status bits are written and every other status bit is unchanged. new_hpstate equals cur_hpstate.

  | Status bit | New value |
  |---|---|
  | 4 | 1 |
  | 3 | 0 |
  | 1 | 0 |
  | 2 | 1 |
  | 9 | old bit 8 |

- R8: On a hyperprivileged entry (to_hyper high, red_trap low), the status word is updated as in R7, except that bit 9 becomes 0 and bit 2 is unchanged. In the hypervisor status word, bit 5 is cleared, bit 2 is set, bit 10 is cleared, and the other bits are unchanged.
- R9: On an error-state entry (red_trap high, whatever to_hyper is), every status bit is 0 except bit 2, which keeps its old value, and bit 4, which is 1. Hypervisor status bit 5 is set and its other bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Commit a trap entry this cycle |
| to_hyper | input | 1 | Entry goes to hyperprivileged mode |
| red_trap | input | 1 | Entry is an error-state entry |
| trap_type | input | 8 | Trap type code to save |
| cur_pc | input | 64 | Current program counter |
| cur_npc | input | 64 | Current next program counter |
| cur_pstate | input | 12 | Current processor status word |
| cur_hpstate | input | 12 | Current hypervisor status word |
| cur_tl | input | 3 | Current trap level |
| cur_gl | input | 3 | Current global level |
| saved_pc | output | 64 | Saved program counter |
| saved_npc | output | 64 | Saved next program counter |
| saved_state | output | 64 | Packed saved-state word |
| new_pstate | output | 12 | Updated processor status word |
| new_hpstate | output | 12 | Updated hypervisor status word |
| new_tl | output | 3 | Updated trap level |
| new_gl | output | 3 | Updated global level |

## Verification
The hardest situations to reach are the ones where two entry-kind selects collide with unusual current state. Examples are an error-state request made together with the hyperprivileged select, and a status word with every bit set so that "unchanged" and "cleared" bits can be told apart. The stimulus reaches these directly through the current-state inputs. It loads all-ones and alternating patterns into both status words, sets upper program-counter bits alongside the address-mask bit, and drives global levels below, at and above the cap.

// File: rtl/trap_entry_pkg.sv
// Package: shared field positions and the entry-kind type for the trap
// entry state updater. Assumes status words of at least 11 bits.
package trap_entry_pkg;
    // processor status word bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;
    // hypervisor status word bit positions
    localparam int HS_HPRIV = 2;
    localparam int HS_RED   = 5;
    localparam int HS_IBE   = 10;
    // saved-state word layout
    localparam int SV_W     = 64;
    localparam int SV_GL_LO = 40;
    localparam int SV_PS_LO = 8;
    localparam int GL_W     = 3;

    typedef enum logic [1:0] {
        ENTRY_PRIV  = 2'd0,
        ENTRY_HYPER = 2'd1,
        ENTRY_RED   = 2'd2
    } entry_kind_e;
endpackage

// File: rtl/trap_pc_mask.sv
// Module: trap_pc_mask
// Passes a program counter through and, when the address mask is set,
// zeroes every bit at or above KEEP_W. Assumes KEEP_W >= 1.
module trap_pc_mask #(
    parameter int PC_W   = 64,
    parameter int KEEP_W = 32
) (
    input  logic            mask_en,
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] pc_out
);
    generate
        if (PC_W > KEEP_W) begin : g_trunc
            localparam int HI_W = PC_W - KEEP_W;
            // purpose: select the full or the truncated address
            always_comb begin
                pc_out = pc_in;
                if (mask_en) begin
                    pc_out = {{HI_W{1'b0}}, pc_in[KEEP_W-1:0]};
                end
            end
        end else begin : g_pass
            // purpose: the counter is already no wider than the mask
            always_comb begin
                pc_out = pc_in;
            end
        end
    endgenerate
endmodule

// File: rtl/trap_status_calc.sv
// Module: trap_status_calc
// Applies the per-entry-kind bit rules to the processor and hypervisor
// status words. Purely combinational. Assumes both words are wider than
// bit 10.
module trap_status_calc
    import trap_entry_pkg::*;
#(
    parameter int PS_W = 12,
    parameter int HS_W = 12
) (
    input  entry_kind_e     kind,
    input  logic [PS_W-1:0] ps_in,
    input  logic [HS_W-1:0] hs_in,
    output logic [PS_W-1:0] ps_out,
    output logic [HS_W-1:0] hs_out
);
    logic [PS_W-1:0] ps_common;

    // purpose: bits that privileged and hyperprivileged entries share
    always_comb begin
        ps_common         = ps_in;
        ps_common[PS_PEF] = 1'b1;
        ps_common[PS_AM]  = 1'b0;
        ps_common[PS_IE]  = 1'b0;
    end

    // purpose: pick the final words according to the entry kind
    always_comb begin
        ps_out = ps_common;
        hs_out = hs_in;
        case (kind)
            ENTRY_RED: begin
                ps_out          = '0;
                ps_out[PS_PRIV] = ps_in[PS_PRIV];
                ps_out[PS_PEF]  = 1'b1;
                hs_out[HS_RED]  = 1'b1;
            end
            ENTRY_HYPER: begin
                ps_out[PS_CLE]   = 1'b0;
                hs_out[HS_RED]   = 1'b0;
                hs_out[HS_HPRIV] = 1'b1;
                hs_out[HS_IBE]   = 1'b0;
            end
            default: begin
                ps_out[PS_PRIV] = 1'b1;
                ps_out[PS_CLE]  = ps_in[PS_TLE];
            end
        endcase
    end
endmodule

// File: rtl/trap_level_calc.sv
// Module: trap_level_calc
// Next trap level (wrapping increment) and next global level (increment
// saturating at MAX_GL). Assumes MAX_GL fits in GL_W bits.
module trap_level_calc
    import trap_entry_pkg::*;
#(
    parameter int TL_W   = 3,
    parameter int MAX_GL = 2
) (
    input  logic [TL_W-1:0] tl_in,
    input  logic [GL_W-1:0] gl_in,
    output logic [TL_W-1:0] tl_out,
    output logic [GL_W-1:0] gl_out
);
    localparam logic [GL_W-1:0] GL_CAP = GL_W'(MAX_GL);

    // purpose: step the trap level
    always_comb begin
        tl_out = tl_in + TL_W'(1);
    end

    // purpose: step the global level without passing the cap
    always_comb begin
        if (gl_in >= GL_CAP) begin
            gl_out = GL_CAP;
        end else begin
            gl_out = gl_in + GL_W'(1);
        end
    end
endmodule

// File: rtl/trap_entry_unit.sv
// Module: trap_entry_unit (top)
// Computes and registers the complete new control state on a trap request.
// Assumes the caller feeds its registered outputs back as cur_* inputs.
// All outputs change only on a clock edge with trap_req high.
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int KEEP_W = 32,
    parameter int PS_W   = 12,
    parameter int HS_W   = 12,
    parameter int TL_W   = 3,
    parameter int TT_W   = 8,
    parameter int MAX_GL = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic            to_hyper,
    input  logic            red_trap,
    input  logic [TT_W-1:0] trap_type,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [PC_W-1:0] cur_npc,
    input  logic [PS_W-1:0] cur_pstate,
    input  logic [HS_W-1:0] cur_hpstate,
    input  logic [TL_W-1:0] cur_tl,
    input  logic [GL_W-1:0] cur_gl,
    output logic [PC_W-1:0] saved_pc,
    output logic [PC_W-1:0] saved_npc,
    output logic [SV_W-1:0] saved_state,
    output logic [PS_W-1:0] new_pstate,
    output logic [HS_W-1:0] new_hpstate,
    output logic [TL_W-1:0] new_tl,
    output logic [GL_W-1:0] new_gl
);
    localparam logic [GL_W-1:0] GL_CAP = GL_W'(MAX_GL);

    entry_kind_e     kind;
    logic [PC_W-1:0] pc_d, npc_d;
    logic [PS_W-1:0] ps_d;
    logic [HS_W-1:0] hs_d;
    logic [TL_W-1:0] tl_d;
    logic [GL_W-1:0] gl_d;
    logic [SV_W-1:0] sv_d;

    // purpose: decode the entry kind, error-state first
    always_comb begin
        if (red_trap)      kind = ENTRY_RED;
        else if (to_hyper) kind = ENTRY_HYPER;
        else               kind = ENTRY_PRIV;
    end

    // purpose: pack the saved-state word
    always_comb begin
        sv_d                      = '0;
        sv_d[SV_GL_LO +: GL_W]    = cur_gl;
        sv_d[SV_PS_LO +: PS_W]    = cur_pstate;
        sv_d[TT_W-1:0]            = trap_type;
    end

    trap_pc_mask #(.PC_W(PC_W), .KEEP_W(KEEP_W)) u_pc_mask (
        .mask_en (cur_pstate[PS_AM]),
        .pc_in   (cur_pc),
        .pc_out  (pc_d)
    );

    trap_pc_mask #(.PC_W(PC_W), .KEEP_W(KEEP_W)) u_npc_mask (
        .mask_en (cur_pstate[PS_AM]),
        .pc_in   (cur_npc),
        .pc_out  (npc_d)
    );

    trap_status_calc #(.PS_W(PS_W), .HS_W(HS_W)) u_status (
        .kind   (kind),
        .ps_in  (cur_pstate),
        .hs_in  (cur_hpstate),
        .ps_out (ps_d),
        .hs_out (hs_d)
    );

    trap_level_calc #(.TL_W(TL_W), .MAX_GL(MAX_GL)) u_levels (
        .tl_in  (cur_tl),
        .gl_in  (cur_gl),
        .tl_out (tl_d),
        .gl_out (gl_d)
    );

    // purpose: commit all new state together on a trap, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_pc    <= '0;
            saved_npc   <= '0;
            saved_state <= '0;
            new_pstate  <= '0;
            new_hpstate <= '0;
            new_tl      <= '0;
            new_gl      <= '0;
        end else if (trap_req) begin
            saved_pc    <= pc_d;
            saved_npc   <= npc_d;
            saved_state <= sv_d;
            new_pstate  <= ps_d;
            new_hpstate <= hs_d;
            new_tl      <= tl_d;
            new_gl      <= gl_d;
        end
    end

    // R2: no request, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> ($stable(new_pstate) && $stable(new_hpstate) &&
                       $stable(new_tl) && $stable(new_gl) && $stable(saved_pc)));

    // R3: trap level steps by one
    a_r3_tl_step: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> new_tl == $past(cur_tl) + TL_W'(1));

    // R4: global level never passes the cap
    a_r4_gl_cap: assert property (@(posedge clk) disable iff (!rst_n)
        new_gl <= GL_CAP);

    // R5: old global level lands in the saved word
    a_r5_gl_saved: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> saved_state[SV_GL_LO +: GL_W] == $past(cur_gl));

    // R6: masked addresses have clear upper bits
    a_r6_am_trunc: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_pstate[PS_AM]) |=>
            ((saved_pc >> KEEP_W) == '0 && (saved_npc >> KEEP_W) == '0));

    // R8: hyperprivileged entry sets hpriv, clears red
    a_r8_hyper: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && to_hyper && !red_trap) |=>
            (new_hpstate[HS_HPRIV] && !new_hpstate[HS_RED] && !new_pstate[PS_CLE]));

    // R9: error-state entry leaves at most two status bits set
    a_r9_red: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && red_trap) |=>
            (new_pstate[PS_PEF] && new_hpstate[HS_RED] && $countones(new_pstate) <= 2));
endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0, to_hyper = 1'b0, red_trap = 1'b0;
    logic [7:0]  trap_type = '0;
    logic [63:0] cur_pc = '0, cur_npc = '0;
    logic [11:0] cur_pstate = '0, cur_hpstate = '0;
    logic [2:0]  cur_tl = '0, cur_gl = '0;
    logic [63:0] saved_pc, saved_npc, saved_state;
    logic [11:0] new_pstate, new_hpstate;
    logic [2:0]  new_tl, new_gl;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trap_entry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .to_hyper(to_hyper),
        .red_trap(red_trap), .trap_type(trap_type), .cur_pc(cur_pc),
        .cur_npc(cur_npc), .cur_pstate(cur_pstate), .cur_hpstate(cur_hpstate),
        .cur_tl(cur_tl), .cur_gl(cur_gl), .saved_pc(saved_pc),
        .saved_npc(saved_npc), .saved_state(saved_state),
        .new_pstate(new_pstate), .new_hpstate(new_hpstate),
        .new_tl(new_tl), .new_gl(new_gl)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7/R8/R9 expectations written from the requirement text
    function automatic logic [11:0] exp_ps(input bit red, input bit hyp, input logic [11:0] ps);
        logic [11:0] r;
        if (red) begin
            r = '0; r[2] = ps[2]; r[4] = 1'b1;
        end else begin
            r = ps; r[4] = 1'b1; r[3] = 1'b0; r[1] = 1'b0;
            if (hyp) r[9] = 1'b0;
            else begin r[2] = 1'b1; r[9] = ps[8]; end
        end
        return r;
    endfunction

    function automatic logic [11:0] exp_hs(input bit red, input bit hyp, input logic [11:0] hs);
        logic [11:0] r = hs;
        if (red) r[5] = 1'b1;
        else if (hyp) begin r[5] = 1'b0; r[2] = 1'b1; r[10] = 1'b0; end
        return r;
    endfunction

    // one trap entry, committed on the next edge, sampled at the falling edge after
    task automatic fire(input bit red, input bit hyp, input logic [7:0] tt,
                        input logic [63:0] pc, input logic [63:0] npc,
                        input logic [11:0] ps, input logic [11:0] hs,
                        input logic [2:0] tl, input logic [2:0] gl);
        @(negedge clk);
        red_trap = red; to_hyper = hyp; trap_type = tt; cur_pc = pc; cur_npc = npc;
        cur_pstate = ps; cur_hpstate = hs; cur_tl = tl; cur_gl = gl; trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 saved_pc", saved_pc, 64'h0);
        check("R1 saved_npc", saved_npc, 64'h0);
        check("R1 saved_state", saved_state, 64'h0);
        check("R1 pstate", {52'h0, new_pstate}, 64'h0);
        check("R1 hpstate", {52'h0, new_hpstate}, 64'h0);
        check("R1 tl_gl", {58'h0, new_tl, new_gl}, 64'h0);
    endtask

    task automatic t_priv;
        fire(0, 0, 8'h41, 64'hDEAD_BEEF_1234_5670, 64'hDEAD_BEEF_1234_5674,
             12'h102, 12'h5A5, 3'd1, 3'd0);
        check("R6 pc full", saved_pc, 64'hDEAD_BEEF_1234_5670);
        check("R6 npc full", saved_npc, 64'hDEAD_BEEF_1234_5674);
        check("R7 pstate", {52'h0, new_pstate}, {52'h0, exp_ps(0, 0, 12'h102)});
        check("R7 hpstate", {52'h0, new_hpstate}, 64'h5A5);
        check("R3 tl", {61'h0, new_tl}, 64'd2);
        check("R4 gl", {61'h0, new_gl}, 64'd1);
        check("R5 saved", saved_state, (64'd0 << 40) | (64'h102 << 8) | 64'h41);
        fire(0, 0, 8'h08, 64'h0, 64'h4, 12'hEFF, 12'h000, 3'd0, 3'd1);
        check("R7 pstate tle0", {52'h0, new_pstate}, {52'h0, exp_ps(0, 0, 12'hEFF)});
        check("R4 gl to cap", {61'h0, new_gl}, 64'd2);
    endtask

    task automatic t_mask;
        fire(0, 0, 8'h10, 64'hFFFF_0000_8000_0004, 64'h1234_5678_9ABC_DEF0,
             12'h00C, 12'h000, 3'd3, 3'd2);
        check("R6 pc trunc", saved_pc, 64'h0000_0000_8000_0004);
        check("R6 npc trunc", saved_npc, 64'h0000_0000_9ABC_DEF0);
        check("R4 gl at cap", {61'h0, new_gl}, 64'd2);
        check("R5 saved gl2", saved_state, (64'd2 << 40) | (64'h00C << 8) | 64'h10);
    endtask

    task automatic t_hyper;
        fire(0, 1, 8'h7F, 64'h1, 64'h2, 12'hFFF, 12'hFFF, 3'd7, 3'd5);
        check("R8 pstate", {52'h0, new_pstate}, {52'h0, exp_ps(0, 1, 12'hFFF)});
        check("R8 hpstate", {52'h0, new_hpstate}, {52'h0, exp_hs(0, 1, 12'hFFF)});
        check("R3 tl wrap", {61'h0, new_tl}, 64'd0);
        check("R4 gl above cap", {61'h0, new_gl}, 64'd2);
        check("R6 pc am set trunc", saved_pc, 64'h1);
        fire(0, 1, 8'h01, 64'h5, 64'h9, 12'h300, 12'h000, 3'd2, 3'd0);
        check("R8 pstate priv kept0", {52'h0, new_pstate}, {52'h0, exp_ps(0, 1, 12'h300)});
        check("R8 hpstate from 0", {52'h0, new_hpstate}, 64'h004);
    endtask

    task automatic t_red;
        fire(1, 0, 8'hFF, 64'hAAAA_5555_0000_1111, 64'h0, 12'hFFF, 12'h000, 3'd4, 3'd1);
        check("R9 pstate", {52'h0, new_pstate}, 64'h014);
        check("R9 hpstate", {52'h0, new_hpstate}, 64'h020);
        check("R6 red trunc", saved_pc, 64'h0000_0000_0000_1111);
        fire(1, 1, 8'h22, 64'h8, 64'hC, 12'hAAB, 12'h404, 3'd5, 3'd0);
        check("R9 red over hyper ps", {52'h0, new_pstate}, {52'h0, exp_ps(1, 0, 12'hAAB)});
        check("R9 red over hyper hs", {52'h0, new_hpstate}, 64'h424);
        check("R5 saved red", saved_state, (64'hAAB << 8) | 64'h22);
    endtask

    task automatic t_hold;
        logic [63:0] p, s;
        logic [11:0] ps, hs;
        logic [2:0]  tl, gl;
        p = saved_pc; s = saved_state; ps = new_pstate; hs = new_hpstate;
        tl = new_tl; gl = new_gl;
        @(negedge clk);
        red_trap = 1'b0; to_hyper = 1'b1; cur_pc = '1; cur_npc = '1; cur_pstate = '1;
        cur_hpstate = '0; cur_tl = 3'd6; cur_gl = 3'd1; trap_type = 8'h5C;
        repeat (3) @(negedge clk);
        check("R2 hold pc", saved_pc, p);
        check("R2 hold state", saved_state, s);
        check("R2 hold ps hs", {40'h0, ps, hs}, {40'h0, new_pstate, new_hpstate});
        check("R2 hold levels", {58'h0, tl, gl}, {58'h0, new_tl, new_gl});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priv();
        t_mask();
        t_hyper();
        t_red();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule